// File: doc/BRIEF.md
# Two-Bank Edge-Capturing Interrupt Aggregator

This block gathers a wide vector of asynchronous interrupt sources, split into equal banks (two banks of 32 by default), and turns them into a single edge-style request line for a host processor plus a separate wake line. Every source is synchronised, compared against a per-source polarity bit to choose rising or falling detection, and a detected edge sets a sticky pending bit. The host reads pending bits, clears them by writing ones, and masks each source's effect on the request line with an enable bit.

Because the host only reacts to edges on the request line, the block guarantees a fresh edge after every clear that leaves enabled work behind: the line is pulled low for one cycle on any clear and rises again if anything enabled is still pending. The polarity bit enters the edge detector itself, so toggling it on a steady input is seen as an edge. A second detector per source, with its own polarity and enable, drives the wake line, which stays high until the matching pending bits are cleared.

Register access is a plain single-cycle bus: one write strobe, an address whose upper bit picks the bank and whose lower three bits pick the register, and a combinational read path.

Top module: `edge_irq_ctrl`

## Requirements
- R1: After reset every enable, edge-polarity, pending, wake-enable and wake-polarity register reads 0, and `irq_out` and `wake_out` are low.
- R2: Address bits [2:0] select the register (0 enable, 1 edge polarity, 2 pending, 3 wake enable, 4 wake polarity; codes 5 to 7 read 0) and address bit 3 selects the bank (0 holds sources 0 to 31, 1 holds sources 32 to 63, source n at bit n mod 32); written registers read back the written value.
- R3: With edge polarity 0, a 0-to-1 change on a source sets its pending bit; an input change set up before clock edge e is visible in the pending register after edge e+2, and only that one bit in that one bank is set.
- R4: With edge polarity 1, a 1-to-0 change on a source sets its pending bit with the same latency, and a 0-to-1 change sets nothing.
- R5: Changing a source's polarity bit on a steady input counts as an edge whenever the polarity-adjusted level goes from 0 to 1; flipping and then restoring the bit always sets the pending bit.
- R6: A pending bit is set whatever its enable bit is; `irq_out` is the OR over both banks of pending AND enable, registered, so it follows the pending register by one cycle and rises one cycle after an enable write exposes a pending bit.
- R7: Writing the pending register clears exactly the bits written as 1; writing all ones clears the whole bank; bits written as 0 and the other bank are untouched.
- R8: When a clear and a new edge hit the same pending bit in the same cycle, the bit ends set.
- R9: A pending-register write with any 1 bit forces `irq_out` low in the next cycle; if enabled pending bits remain, `irq_out` is high again the cycle after.
- R10: `wake_out` goes high one cycle-free step after a wake-enabled source shows a 0-to-1 change of its level XOR wake polarity (same e+2 latency), ignores sources whose wake enable is 0, and stays high until that source's pending bit is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_in | input | 64 | Raw interrupt sources, bank-major |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Bit 3 bank, bits [2:0] register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_out | output | 1 | Registered request line toward the host |
| wake_out | output | 1 | Wake request line |

## Verification
The collision that matters is a pending-register clear landing in the same cycle as a new edge on the bit being cleared, together with the forced low of the request line that every clear causes. The bench times a source change two cycles ahead of the clear so that the synchronised edge and the write meet at one clock edge, then judges that the bit survives, the neighbouring cleared bit does not, and the request line dips for exactly one cycle before rising again. The re-pulse is separately judged with two enabled sources in different banks, clearing one at a time.

// File: rtl/eic_pkg.sv
package eic_pkg;
   localparam int FIELD_AW = 3;

   typedef enum logic [FIELD_AW-1:0] {
      FLD_ENABLE   = 3'd0,
      FLD_EDGE_POL = 3'd1,
      FLD_PENDING  = 3'd2,
      FLD_WAKE_EN  = 3'd3,
      FLD_WAKE_POL = 3'd4
   } eic_field_e;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
   parameter int W      = 32,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (W < 1) begin : g_bad_width
      $error("eic_sync: W must be at least 1");
   end
   if (STAGES < 2) begin : g_bad_stages
      $error("eic_sync: STAGES must be at least 2");
   end

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/eic_bank.sv
module eic_bank
   import eic_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sync_in,
   input  logic         wr_sel,
   input  eic_field_e   field,
   input  logic [W-1:0] wdata,
   output logic [W-1:0] rdata,
   output logic         pend_any,
   output logic         wake_any
);
   logic [W-1:0] en_q, pol_q, stat_q, wen_q, wpol_q;
   logic [W-1:0] sense_q, wsense_q, wpend_q;
   logic [W-1:0] sense_now, wsense_now, edge_hit, wedge_hit, clr_mask;

   // polarity is folded in before the history register, so a polarity
   // change is indistinguishable from an input change
   assign sense_now  = sync_in ^ pol_q;
   assign wsense_now = sync_in ^ wpol_q;
   assign edge_hit   = sense_now & ~sense_q;
   assign wedge_hit  = wsense_now & ~wsense_q;
   assign clr_mask   = (wr_sel && field == FLD_PENDING) ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q     <= '0;
         pol_q    <= '0;
         stat_q   <= '0;
         wen_q    <= '0;
         wpol_q   <= '0;
         sense_q  <= '0;
         wsense_q <= '0;
         wpend_q  <= '0;
      end else begin
         sense_q  <= sense_now;
         wsense_q <= wsense_now;
         stat_q   <= (stat_q & ~clr_mask) | edge_hit;
         wpend_q  <= (wpend_q & ~clr_mask) | (wedge_hit & wen_q);
         if (wr_sel) begin
            case (field)
               FLD_ENABLE:   en_q   <= wdata;
               FLD_EDGE_POL: pol_q  <= wdata;
               FLD_WAKE_EN:  wen_q  <= wdata;
               FLD_WAKE_POL: wpol_q <= wdata;
               default:      ;
            endcase
         end
      end
   end

   always_comb begin
      case (field)
         FLD_ENABLE:   rdata = en_q;
         FLD_EDGE_POL: rdata = pol_q;
         FLD_PENDING:  rdata = stat_q;
         FLD_WAKE_EN:  rdata = wen_q;
         FLD_WAKE_POL: rdata = wpol_q;
         default:      rdata = '0;
      endcase
   end

   assign pend_any = |(stat_q & en_q);
   assign wake_any = |wpend_q;

   AST_SET_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (|edge_hit) |=> ((stat_q & $past(edge_hit)) == $past(edge_hit))); // R3
   AST_STICKY_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (|stat_q) |=> ((stat_q & $past(stat_q & ~clr_mask)) == $past(stat_q & ~clr_mask))); // R7
   AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_mask & ~edge_hit)) |=> ((stat_q & $past(clr_mask & ~edge_hit)) == '0)); // R7
   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (|(clr_mask & edge_hit)) |=> ((stat_q & $past(clr_mask & edge_hit)) == $past(clr_mask & edge_hit))); // R8
   AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      (|wpend_q) || 1'b1 |=> (((wpend_q & ~$past(wpend_q)) & ~$past(wen_q)) == '0)); // R10
endmodule

// File: rtl/edge_irq_ctrl.sv
module edge_irq_ctrl
   import eic_pkg::*;
#(
   parameter int BANK_W      = 32,
   parameter int NUM_BANKS   = 2,
   parameter int SYNC_STAGES = 2,
   localparam int SRC_W      = BANK_W * NUM_BANKS,
   localparam int BANK_AW    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
   localparam int ADDR_W     = FIELD_AW + BANK_AW
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SRC_W-1:0]  src_in,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [BANK_W-1:0] reg_wdata,
   output logic [BANK_W-1:0] reg_rdata,
   output logic              irq_out,
   output logic              wake_out
);
   if (BANK_W < 1) begin : g_bad_bank_w
      $error("edge_irq_ctrl: BANK_W must be at least 1");
   end
   if (NUM_BANKS < 2 || (NUM_BANKS & (NUM_BANKS - 1)) != 0) begin : g_bad_banks
      $error("edge_irq_ctrl: NUM_BANKS must be a power of two, at least 2");
   end

   logic [SRC_W-1:0]   src_sync;
   eic_field_e         fld;
   logic [BANK_AW-1:0] bank_idx;
   logic [BANK_W-1:0]  bank_rdata [NUM_BANKS];
   logic [NUM_BANKS-1:0] bank_pend, bank_wake;
   logic               pend_any, stat_wr, clr_hit, irq_q;

   assign fld      = eic_field_e'(reg_addr[FIELD_AW-1:0]);
   assign bank_idx = reg_addr[ADDR_W-1:FIELD_AW];

   eic_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .d   (src_in),
      .q   (src_sync)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      eic_bank #(.W(BANK_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .sync_in  (src_sync[b*BANK_W +: BANK_W]),
         .wr_sel   (reg_wr && bank_idx == BANK_AW'(b)),
         .field    (fld),
         .wdata    (reg_wdata),
         .rdata    (bank_rdata[b]),
         .pend_any (bank_pend[b]),
         .wake_any (bank_wake[b])
      );
   end

   assign reg_rdata = bank_rdata[bank_idx];
   assign pend_any  = |bank_pend;
   assign stat_wr   = reg_wr && fld == FLD_PENDING;
   assign clr_hit   = stat_wr && (|reg_wdata);

   // a clear always drops the line for one cycle; remaining work re-raises it
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= pend_any && !clr_hit;
   end

   assign irq_out  = irq_q;
   assign wake_out = |bank_wake;

   AST_CLEAR_DROPS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit |=> !irq_out); // R9
   AST_IRQ_REPULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_hit ##1 (pend_any && !clr_hit)) |=> irq_out); // R9
   AST_IRQ_FROM_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      irq_out |-> $past(pend_any)); // R6
   AST_WAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (wake_out && !stat_wr) |=> wake_out); // R10
endmodule

// File: tb/edge_irq_ctrl_test.sv
module edge_irq_ctrl_test;
   localparam int CLK_PERIOD = 10;
   localparam int F_EN = 0, F_POL = 1, F_PEND = 2, F_WEN = 3, F_WPOL = 4;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [63:0] src;
   logic        reg_wr;
   logic [3:0]  reg_addr;
   logic [31:0] reg_wdata;
   logic [31:0] reg_rdata;
   logic        irq_out, wake_out;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   edge_irq_ctrl uut (
      .clk (clk), .rst_n (rst_n), .src_in (src), .reg_wr (reg_wr),
      .reg_addr (reg_addr), .reg_wdata (reg_wdata), .reg_rdata (reg_rdata),
      .irq_out (irq_out), .wake_out (wake_out)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input int bank, input int fld, input logic [31:0] d);
      reg_wr = 1'b1; reg_addr = {bank[0], fld[2:0]}; reg_wdata = d;
      tick(1);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input int bank, input int fld, output logic [31:0] d);
      reg_addr = {bank[0], fld[2:0]};
      #1 d = reg_rdata;
   endtask

   initial begin
      #(CLK_PERIOD*200000);
      errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      rst_n = 1'b0; src = '0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      chk("R1 irq", irq_out, 0);
      chk("R1 wake", wake_out, 0);
      for (int b = 0; b < 2; b++)
         for (int f = 0; f < 5; f++) begin
            rd(b, f, v); chk("R1 reg", v, 0);
         end

      // R2 readback and decode
      wr(0, F_EN, 32'hA5A5_0F0F);
      rd(0, F_EN, v); chk("R2 en readback", v, 32'hA5A5_0F0F);
      rd(1, F_EN, v); chk("R2 other bank", v, 0);
      wr(1, F_WPOL, 32'h1234_5678);
      rd(1, F_WPOL, v); chk("R2 wpol readback", v, 32'h1234_5678);
      rd(0, 5, v); chk("R2 unused code", v, 0);
      wr(1, F_WPOL, 0);
      wr(0, F_EN, 32'hFFFF_FFFF);
      wr(1, F_EN, 32'hFFFF_FFFF);

      // R3 R6 R9 R11 rising sweep over all sources
      for (int i = 0; i < 64; i++) begin
         src[i] = 1'b1;
         tick(3);
         rd(i / 32, F_PEND, v); chk("R3 rise sets bit", v, 32'h1 << (i % 32));
         rd(1 - i / 32, F_PEND, v); chk("R3 other bank clean", v, 0);
         chk("R6 irq lags pending", irq_out, 0);
         tick(1);
         chk("R6 irq high", irq_out, 1);
         src[i] = 1'b0;
         wr(i / 32, F_PEND, 32'h1 << (i % 32));
         chk("R9 irq drops on clear", irq_out, 0);
         rd(i / 32, F_PEND, v); chk("R7 bit cleared", v, 0);
         tick(2);
         chk("R3 fall ignored with pol 0", irq_out, 0);
      end

      // R6 enable gates only the output
      wr(0, F_EN, 0);
      src[3] = 1'b1;
      tick(4);
      rd(0, F_PEND, v); chk("R6 pending without enable", v, 32'h8);
      chk("R6 masked irq", irq_out, 0);
      wr(0, F_EN, 32'h8);
      tick(1);
      chk("R6 irq after enable", irq_out, 1);
      src[3] = 1'b0;
      wr(0, F_PEND, 32'hFFFF_FFFF);
      wr(0, F_EN, 32'hFFFF_FFFF);

      // R9 re-pulse with two banks pending
      src[1] = 1'b1; src[40] = 1'b1;
      tick(4);
      chk("R9 irq both pending", irq_out, 1);
      wr(0, F_PEND, 32'h2);
      chk("R9 low after first clear", irq_out, 0);
      tick(1);
      chk("R9 re-pulse", irq_out, 1);
      rd(1, F_PEND, v); chk("R7 other bank untouched", v, 32'h100);
      wr(1, F_PEND, 32'h100);
      chk("R9 low after last clear", irq_out, 0);
      tick(1);
      chk("R9 stays low when empty", irq_out, 0);
      src[1] = 1'b0; src[40] = 1'b0;
      tick(3);

      // R8 clear and new edge in the same cycle
      src[9] = 1'b1;
      tick(4);
      src[9] = 1'b0;
      src[7] = 1'b1;
      tick(2);
      wr(0, F_PEND, 32'h280);
      rd(0, F_PEND, v); chk("R8 set wins, neighbour cleared", v, 32'h80);
      chk("R8 irq dips on collision", irq_out, 0);
      tick(1);
      chk("R8 irq returns", irq_out, 1);
      src[7] = 1'b0;
      wr(0, F_PEND, 32'hFFFF_FFFF);

      // R5 polarity flip on steady low input
      wr(1, F_POL, 32'h10);
      wr(1, F_POL, 0);
      tick(1);
      rd(1, F_PEND, v); chk("R5 flip low input", v, 32'h10);
      wr(1, F_PEND, 32'hFFFF_FFFF);
      // R5 polarity flip on steady high input
      src[2] = 1'b1;
      tick(3);
      wr(0, F_PEND, 32'h4);
      wr(0, F_POL, 32'h4);
      wr(0, F_POL, 0);
      tick(1);
      rd(0, F_PEND, v); chk("R5 flip high input", v, 32'h4);
      src[2] = 1'b0;
      wr(0, F_PEND, 32'hFFFF_FFFF);
      tick(2);

      // R4 falling sweep
      wr(0, F_POL, 32'hFFFF_FFFF);
      wr(1, F_POL, 32'hFFFF_FFFF);
      tick(1);
      rd(0, F_PEND, v); chk("R5 bulk polarity change", v, 32'hFFFF_FFFF);
      rd(1, F_PEND, v); chk("R5 bulk polarity change", v, 32'hFFFF_FFFF);
      src = '1;
      tick(3);
      wr(0, F_PEND, 32'hFFFF_FFFF);
      wr(1, F_PEND, 32'hFFFF_FFFF);
      tick(1);
      rd(0, F_PEND, v); chk("R4 rise ignored with pol 1", v, 0);
      rd(1, F_PEND, v); chk("R7 bulk clear", v, 0);
      for (int i = 0; i < 64; i++) begin
         src[i] = 1'b0;
         tick(3);
         rd(i / 32, F_PEND, v); chk("R4 fall sets bit", v, 32'h1 << (i % 32));
         tick(1);
         chk("R4 irq high", irq_out, 1);
         src[i] = 1'b1;
         wr(i / 32, F_PEND, 32'hFFFF_FFFF);
         tick(3);
         rd(i / 32, F_PEND, v); chk("R4 rise ignored", v, 0);
      end
      src = '0;
      tick(3);
      wr(0, F_POL, 0);
      wr(1, F_POL, 0);
      wr(0, F_PEND, 32'hFFFF_FFFF);
      wr(1, F_PEND, 32'hFFFF_FFFF);
      tick(2);
      chk("R7 all clear", irq_out, 0);

      // R10 wake, low bank rising
      wr(0, F_WEN, 32'h20);
      src[6] = 1'b1;
      tick(4);
      chk("R10 non-wake source ignored", wake_out, 0);
      src[5] = 1'b1;
      tick(2);
      chk("R10 wake latency", wake_out, 0);
      tick(1);
      chk("R10 wake set", wake_out, 1);
      wr(0, F_PEND, 32'h40);
      tick(1);
      chk("R10 wake held over other clear", wake_out, 1);
      wr(0, F_PEND, 32'h20);
      chk("R10 wake cleared", wake_out, 0);
      src[5] = 1'b0; src[6] = 1'b0;
      tick(3);
      wr(0, F_PEND, 32'hFFFF_FFFF);
      wr(0, F_WEN, 0);

      // R10 wake, high bank falling sense
      wr(1, F_WPOL, 32'h400);
      tick(1);
      wr(1, F_WEN, 32'h400);
      src[42] = 1'b1;
      tick(4);
      chk("R10 rise ignored with wake pol 1", wake_out, 0);
      src[42] = 1'b0;
      tick(3);
      chk("R10 fall wakes", wake_out, 1);
      wr(1, F_PEND, 32'h400);
      chk("R10 high bank wake cleared", wake_out, 0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule